// File: doc/BRIEF.md
# Clear-on-read interrupt status controller

This block collects single-cycle event pulses from eight internal sources of a radio transceiver and holds them in an 8-bit status register. A mask register selects which held bits may raise a single active-high interrupt request toward the host. When the host reads the status address, it gets the held bits, and the whole register is cleared at the same clock edge. A mode bit controls what happens to a masked event. When the bit is set, the event is still recorded but does not raise the request. When the bit is clear, the event is dropped.

Status bit 4 is shared by two events: the end of a channel assessment or energy measurement, and the end of a wake-up transition. A PLL-unlock pulse that arrives while the transmitter is busy also drives a power-amplifier cut-off output in the same cycle. The register port is a plain one-cycle read/write port with combinational read data. The host bus that drives this port is outside the block.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the status register, mask register and mode bit are all 0, and `irq_o` is low.
- R2: With the mode bit set, a pulse on event source k is latched into status bit k whatever the value of mask bit k. The bit order is: 0 PLL lock, 1 PLL unlock, 2 RX start, 3 frame end, 4 measurement or wake done, 5 address match, 6 frame-buffer violation, 7 supply low.
- R3: With the mode bit clear, a pulse on a source whose mask bit is 0 is not latched.
- R4: `irq_o` is high in the cycle after a latched bit whose mask bit is 1 is set. It stays high until a clearing read, or until that mask bit is written to 0.
- R5: A read at address 0x0F returns the status bits in the same cycle. At the following clock edge, all status bits clear and `irq_o` falls.
- R6: An accepted event that arrives in the same cycle as a clearing read is set in the status register after that edge.
- R7: Status bit 4 is set by a pulse on `ev_i[4]` (measurement done) or on `ev_wake_i` (wake-up done).
- R8: `pa_off_o` is high in exactly those cycles in which `ev_i[1]` (PLL unlock) and `tx_busy_i` are both high.
- R9: A write to the status address 0x0F does not change the status register.
- R10: The mask register is read/write at address 0x0E. The mode bit is read/write at bit 0 of address 0x04, and that register's upper bits read as 0. Reads of any other address, and all cycles without `rd_en_i`, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ev_i | input | 8 | Single-cycle event pulses, one per status bit |
| ev_wake_i | input | 1 | Wake-up done pulse, shares status bit 4 |
| tx_busy_i | input | 1 | Transmitter is in a busy-transmit state |
| pa_off_o | output | 1 | Immediate power-amplifier cut-off request |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, valid in the cycle of the read |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
A status bit that is stuck or lost shows up in the next status read. It can also show as `irq_o` going high or failing to go high one cycle after the event edge. A clear that goes wrong shows in the read that follows. Because of this, every event in the sweep is followed at once by a read of the status register, a check of the request line, and a second read that must return zero. A mode or mask bit that is held wrongly changes which events get latched, and the sweep over all sources, both modes and four mask patterns exposes it within two cycles of the event.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int NSRC   = 8,
  parameter int AW     = 8,
  parameter int A_STAT = 15,
  parameter int A_MASK = 14,
  parameter int A_MODE = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] ev_i,
  input  logic            ev_wake_i,
  input  logic            tx_busy_i,
  output logic            pa_off_o,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq_o
);
  localparam int SHARED = 4;
  localparam int UNLOCK = 1;

  logic [NSRC-1:0] stat_q, mask_q, hit, take;
  logic            mode_q;

  wire sel_stat = addr_i == AW'(A_STAT);
  wire sel_mask = addr_i == AW'(A_MASK);
  wire sel_mode = addr_i == AW'(A_MODE);
  wire clr      = rd_en_i & sel_stat;

  assign hit  = ev_i | (NSRC'(ev_wake_i) << SHARED);
  assign take = mode_q ? hit : (hit & mask_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
      mode_q <= 1'b0;
    end else begin
      stat_q <= (clr ? '0 : stat_q) | take;
      if (wr_en_i && sel_mask) mask_q <= wdata_i;
      if (wr_en_i && sel_mode) mode_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (sel_stat)      rdata_o = stat_q;
      else if (sel_mask) rdata_o = mask_q;
      else if (sel_mode) rdata_o = {{(NSRC-1){1'b0}}, mode_q};
    end
  end

  assign irq_o    = |(stat_q & mask_q);
  assign pa_off_o = ev_i[UNLOCK] & tx_busy_i;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int NSRC   = 8,
  parameter int AW     = 8,
  parameter int A_STAT = 15
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] ev_i,
  input logic            ev_wake_i,
  input logic            tx_busy_i,
  input logic            pa_off_o,
  input logic            wr_en_i,
  input logic            rd_en_i,
  input logic [AW-1:0]   addr_i,
  input logic            irq_o,
  input logic [NSRC-1:0] stat_q,
  input logic [NSRC-1:0] mask_q,
  input logic            mode_q
);
  wire rd_stat = rd_en_i && (addr_i == AW'(A_STAT));
  wire quiet   = (ev_i == '0) && !ev_wake_i;

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && quiet) |=> (stat_q == '0) && !irq_o);

  a_r6_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && ev_i[2] && (mode_q || mask_q[2])) |=> stat_q[2]);

  a_r7_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_wake_i && (mode_q || mask_q[4])) |=> stat_q[4]);

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_stat && !wr_en_i) |=> irq_o);

  a_r3_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && !rd_stat) |=> (((stat_q ^ $past(stat_q)) & ~$past(mask_q)) == '0));

  a_r9_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && (addr_i == AW'(A_STAT)) && quiet) |=> $stable(stat_q));

  a_r8_paoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i[1] && tx_busy_i) |-> pa_off_o);
endmodule

bind irq_status_ctrl irq_status_chk #(.NSRC(NSRC), .AW(AW), .A_STAT(A_STAT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(ev_i), .ev_wake_i(ev_wake_i),
  .tx_busy_i(tx_busy_i), .pa_off_o(pa_off_o), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .addr_i(addr_i), .irq_o(irq_o),
  .stat_q(stat_q), .mask_q(mask_q), .mode_q(mode_q)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  logic       clk = 0, rst_n = 0;
  logic [7:0] ev = 0, addr = 0, wdata = 0, rdata;
  logic       wake = 0, busy = 0, wr = 0, rd = 0, pa_off, irq;
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [7:0] STAT = 8'h0F, MASK = 8'h0E, MODE = 8'h04;

  always #5 clk = ~clk;

  irq_status_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .ev_wake_i(wake), .tx_busy_i(busy),
    .pa_off_o(pa_off), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdreg(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd = 0; addr = 0;
  endtask

  task automatic wrreg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; addr = 0; wdata = 0;
  endtask

  task automatic pulse(logic [7:0] e, logic w);
    @(negedge clk); ev = e; wake = w;
    @(negedge clk); ev = 0; wake = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] pats [4];
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rdreg(STAT, d); chk("R1 stat", d, 8'h00);
    rdreg(MASK, d); chk("R1 mask", d, 8'h00);
    rdreg(MODE, d); chk("R1 mode", d, 8'h00);

    // R2 R3 R4 R5 sweep
    for (int m = 0; m < 2; m++) begin
      wrreg(MODE, 8'(m) | 8'hFE);
      rdreg(MODE, d); chk("R10 mode readback", d, 8'(m));
      for (int k = 0; k < 8; k++) begin
        pats[0] = 8'h00; pats[1] = 8'hFF;
        pats[2] = 8'(1 << k); pats[3] = ~8'(1 << k);
        for (int p = 0; p < 4; p++) begin
          logic lat;
          wrreg(MASK, pats[p]);
          pulse(8'(1 << k), 1'b0);
          lat = (m == 1) || pats[p][k];
          chk(m ? "R2 irq" : "R4 irq", {7'b0, irq}, {7'b0, pats[p][k]});
          rdreg(STAT, d);
          chk(m ? "R2 latch" : "R3 latch", d, lat ? 8'(1 << k) : 8'h00);
          chk("R5 irq cleared", {7'b0, irq}, 8'h00);
          rdreg(STAT, d); chk("R5 stat cleared", d, 8'h00);
        end
      end
    end

    // R10 mask readback and unmapped address
    wrreg(MASK, 8'hA5); rdreg(MASK, d); chk("R10 mask", d, 8'hA5);
    rdreg(8'h33, d); chk("R10 unmapped", d, 8'h00);
    @(negedge clk); addr = MASK; #1 chk("R10 no rd", rdata, 8'h00);

    // R4 clear by mask write
    wrreg(MODE, 8'h00); wrreg(MASK, 8'h08);
    pulse(8'h08, 1'b0);
    chk("R4 set", {7'b0, irq}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R4 hold", {7'b0, irq}, 8'h01);
    wrreg(MASK, 8'h00);
    chk("R4 mask off", {7'b0, irq}, 8'h00);
    rdreg(STAT, d); chk("R4 stat kept", d, 8'h08);

    // R7 shared bit
    wrreg(MASK, 8'h10);
    pulse(8'h00, 1'b1);
    chk("R7 wake irq", {7'b0, irq}, 8'h01);
    rdreg(STAT, d); chk("R7 wake", d, 8'h10);
    pulse(8'h10, 1'b0);
    rdreg(STAT, d); chk("R7 meas", d, 8'h10);
    wrreg(MASK, 8'h00);
    pulse(8'h00, 1'b1);
    rdreg(STAT, d); chk("R7 wake masked", d, 8'h00);

    // R6 collision
    wrreg(MODE, 8'h01);
    pulse(8'h01, 1'b0);
    @(negedge clk); rd = 1; addr = STAT; ev = 8'h08; #1 d = rdata;
    @(negedge clk); rd = 0; addr = 0; ev = 0;
    chk("R6 read old", d, 8'h01);
    rdreg(STAT, d); chk("R6 kept", d, 8'h08);

    // R9 write to status ignored
    pulse(8'h40, 1'b0);
    wrreg(STAT, 8'hFF);
    rdreg(STAT, d); chk("R9 keep", d, 8'h40);
    wrreg(STAT, 8'hFF);
    rdreg(STAT, d); chk("R9 no set", d, 8'h00);

    // R8 power-amplifier cut-off
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); busy = c[0]; ev = c[1] ? 8'h02 : 8'h00;
      #1 chk("R8 pa_off", {7'b0, pa_off}, {7'b0, c == 3});
    end
    @(negedge clk); ev = 8'hFD; busy = 1;
    #1 chk("R8 other ev", {7'b0, pa_off}, 8'h00);
    @(negedge clk); ev = 0; busy = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule